// File: doc/BRIEF.md
# Operand Addressing Mode Resolver

This block turns a decoded operand descriptor into operand values for a 16-bit microcontroller datapath. It holds a 256-byte internal register file and, for each instruction, resolves two source slots. Each slot is a plain register reference, the instruction's immediate value, or an indirect reference through a word register that holds a 16-bit address. A destination register address is checked for alignment along with the sources. Register and immediate operands resolve in the issue cycle without using the memory port. An indirect operand whose address lies above the register file is fetched over a single-cycle request/response port. An indirect address that falls inside the register file is read internally.

Before resolving, the descriptor is checked. A slot kind of immediate or indirect counts as a non-register operand, and only one is allowed per instruction. Word accesses must be aligned in every place they occur. A rejected descriptor raises a one-cycle illegal flag, produces no done strobe and issues no memory request. The datapath fills the register file through a byte/word write port.

Top module: `opnd_resolver`

## Requirements
- R1: Slot kind code 0 reads register-direct. A byte operand is the register byte zero-extended. A word operand is {byte at reg+1, byte at reg}, so the low byte sits at the even address. `done` is high in the issue cycle and `mem_req` stays low.
- R2: Slot kind code 1 yields `imm`, cut to `imm[7:0]` and zero-extended for byte size. `done` is high in the issue cycle and `mem_req` stays low.
- R3: When `size_word` is 1, an odd `dst_reg` or an odd register-direct slot address makes the descriptor illegal. In that cycle `illegal` is 1, and `done` and `mem_req` are 0.
- R4: The descriptor is illegal if both slots are non-register (kind 1 or 2), or if either slot uses the reserved kind code 3.
- R5: Slot kind code 2 is indirect, and its pointer register must be even at any operand size. An odd pointer register makes the descriptor illegal.
- R6: When the indirect address is 0x0100 or above, `mem_req` is 1 in the issue cycle, with `mem_addr` equal to the pointer value and `mem_word` equal to `size_word`. An odd address with word size is illegal instead, and no request is made.
- R7: The cycle after `mem_ack`, `done` is 1. The indirect slot then holds `mem_rdata`, sized as in R1. The other slot holds its value from the issue cycle, even if the register file was written in between.
- R8: An indirect address below 0x0100 reads the internal register file, with no `mem_req`. `done` rises the cycle after issue.
- R9: `ready` is 0 from the cycle after an indirect issue through its `done` cycle. An `issue` seen while `ready` is 0 is ignored: it produces no `done`, no `illegal` and no `mem_req`.
- R10: During reset, `ready` is 1 and `done`, `illegal` and `mem_req` are 0.
- R11: A word write stores `wr_data[7:0]` at the even address and `wr_data[15:8]` at the odd address above it. A byte write changes only the addressed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register file write strobe |
| wr_word | input | 1 | Write size: 1 word, 0 byte |
| wr_addr | input | 8 | Register file write address |
| wr_data | input | 16 | Write data |
| issue | input | 1 | Descriptor valid this cycle |
| size_word | input | 1 | Operand size: 1 word, 0 byte |
| a_kind | input | 2 | Slot A kind: 0 register, 1 immediate, 2 indirect, 3 reserved |
| a_reg | input | 8 | Slot A register or pointer register |
| b_kind | input | 2 | Slot B kind (same coding) |
| b_reg | input | 8 | Slot B register or pointer register |
| dst_reg | input | 8 | Destination register, alignment-checked |
| imm | input | 16 | Immediate value |
| ready | output | 1 | Block can accept a descriptor |
| done | output | 1 | Operands valid |
| illegal | output | 1 | Descriptor rejected |
| opnd_a | output | 16 | Resolved slot A value |
| opnd_b | output | 16 | Resolved slot B value |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_word | output | 1 | Memory read size |
| mem_ack | input | 1 | Memory response valid |
| mem_rdata | input | 16 | Memory response data |

## Verification
A corrupted sequencer state shows up at once at the ports as a stuck-low `ready`, or as a `done` that arrives early, arrives late or never arrives after `mem_ack`. The bench catches this within two cycles of the indirect issue. A bad held operand shows only on the `done` cycle of an indirect access, which is why the bench writes the register file during the wait. Legality errors appear in the issue cycle itself, as a wrong `illegal`, `done` or `mem_req`.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    K_REG = 2'd0,
    K_IMM = 2'd1,
    K_IND = 2'd2,
    K_BAD = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_DONE = 2'd2
  } st_e;

  // Zero-extend a byte operand, pass a word operand through.
  function automatic logic [WORD_W-1:0] fit(input logic is_word, input logic [WORD_W-1:0] d);
    return is_word ? d : {{(WORD_W-BYTE_W){1'b0}}, d[BYTE_W-1:0]};
  endfunction
endpackage

// File: rtl/opnd_regfile.sv
module opnd_regfile
  import opnd_pkg::*;
#(
  parameter int RAW = 8,
  parameter int NRD = 3
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic                  wr_word,
  input  logic [RAW-1:0]        wr_addr,
  input  logic [WORD_W-1:0]     wr_data,
  input  logic [NRD*RAW-1:0]    rd_addr,
  output logic [NRD*WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << RAW;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [RAW-1:0]    lo_idx, hi_idx;
  logic              lo_en, hi_en;
  logic [BYTE_W-1:0] lo_val, hi_val;

  // Write decode: a word write spans the even byte and the odd byte above it.
  always_comb begin
    lo_idx = wr_word ? {wr_addr[RAW-1:1], 1'b0} : wr_addr;
    hi_idx = {wr_addr[RAW-1:1], 1'b1};
    lo_en  = wr_en;
    hi_en  = wr_en & wr_word;
    lo_val = wr_data[BYTE_W-1:0];
    hi_val = wr_data[WORD_W-1:BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (lo_en) mem[lo_idx] <= lo_val;
    if (hi_en) mem[hi_idx] <= hi_val;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic [RAW-1:0] ra;
    assign ra = rd_addr[g*RAW +: RAW];
    assign rd_data[g*WORD_W +: WORD_W] = {mem[{ra[RAW-1:1], 1'b1}], mem[ra]};
  end
endmodule

// File: rtl/opnd_check.sv
module opnd_check
  import opnd_pkg::*;
#(
  parameter int RAW = 8,
  parameter int MAW = 16
) (
  input  logic           size_word,
  input  kind_e          a_kind,
  input  kind_e          b_kind,
  input  logic [RAW-1:0] a_reg,
  input  logic [RAW-1:0] b_reg,
  input  logic [RAW-1:0] dst_reg,
  input  logic [MAW-1:0] ptr_a,
  input  logic [MAW-1:0] ptr_b,
  output logic           legal,
  output logic           use_ind,
  output logic           ind_slot,
  output logic           ind_local,
  output logic [MAW-1:0] ind_addr
);
  logic [1:0] nonreg;
  logic       too_many, bad_kind, reg_mis, ptr_mis, tgt_mis;

  always_comb begin
    nonreg    = {1'b0, a_kind != K_REG} + {1'b0, b_kind != K_REG};
    too_many  = nonreg[1];
    bad_kind  = (a_kind == K_BAD) | (b_kind == K_BAD);
    reg_mis   = size_word & (dst_reg[0]
                | ((a_kind == K_REG) & a_reg[0])
                | ((b_kind == K_REG) & b_reg[0]));
    ptr_mis   = ((a_kind == K_IND) & a_reg[0]) | ((b_kind == K_IND) & b_reg[0]);
    use_ind   = (a_kind == K_IND) | (b_kind == K_IND);
    ind_slot  = (b_kind == K_IND);
    ind_addr  = ind_slot ? ptr_b : ptr_a;
    ind_local = ~|ind_addr[MAW-1:RAW];
    tgt_mis   = use_ind & size_word & ind_addr[0];
    legal     = ~(too_many | bad_kind | reg_mis | ptr_mis | tgt_mis);
  end
endmodule

// File: rtl/opnd_seq.sv
module opnd_seq
  import opnd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_ind,
  input  logic              ind_local,
  input  logic              ind_slot,
  input  logic              size_word,
  input  logic [WORD_W-1:0] val_a,
  input  logic [WORD_W-1:0] val_b,
  input  logic [WORD_W-1:0] local_data,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              ready,
  output logic              hold_v,
  output logic [WORD_W-1:0] hold_a,
  output logic [WORD_W-1:0] hold_b
);
  st_e               st_q, st_d;
  logic              slot_q, slot_d, size_q, size_d;
  logic              ld_a, ld_b;
  logic [WORD_W-1:0] nxt_a, nxt_b, hold_a_q, hold_b_q;

  always_comb begin
    st_d   = st_q;
    slot_d = slot_q;
    size_d = size_q;
    ld_a   = 1'b0;
    ld_b   = 1'b0;
    nxt_a  = val_a;
    nxt_b  = val_b;
    case (st_q)
      S_IDLE: begin
        if (go_ind) begin
          slot_d = ind_slot;
          size_d = size_word;
          st_d   = ind_local ? S_DONE : S_WAIT;
          ld_a   = 1'b1;
          ld_b   = 1'b1;
          if (ind_local && !ind_slot) nxt_a = fit(size_word, local_data);
          if (ind_local &&  ind_slot) nxt_b = fit(size_word, local_data);
        end
      end
      S_WAIT: begin
        if (mem_ack) begin
          st_d  = S_DONE;
          ld_a  = ~slot_q;
          ld_b  = slot_q;
          nxt_a = fit(size_q, mem_rdata);
          nxt_b = fit(size_q, mem_rdata);
        end
      end
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      slot_q <= 1'b0;
      size_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      slot_q <= slot_d;
      size_q <= size_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_a) hold_a_q <= nxt_a;
    if (ld_b) hold_b_q <= nxt_b;
  end

  assign ready  = (st_q == S_IDLE);
  assign hold_v = (st_q == S_DONE);
  assign hold_a = hold_a_q;
  assign hold_b = hold_b_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v |=> ready); // R9
  AST_WAIT_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_WAIT) && !mem_ack) |=> !hold_v); // R7
endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver
  import opnd_pkg::*;
#(
  parameter int RAW = 8,
  parameter int MAW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_word,
  input  logic [RAW-1:0]    wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              issue,
  input  logic              size_word,
  input  logic [1:0]        a_kind,
  input  logic [RAW-1:0]    a_reg,
  input  logic [1:0]        b_kind,
  input  logic [RAW-1:0]    b_reg,
  input  logic [RAW-1:0]    dst_reg,
  input  logic [WORD_W-1:0] imm,
  output logic              ready,
  output logic              done,
  output logic              illegal,
  output logic [WORD_W-1:0] opnd_a,
  output logic [WORD_W-1:0] opnd_b,
  output logic              mem_req,
  output logic [MAW-1:0]    mem_addr,
  output logic              mem_word,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int NRD = 3;

  kind_e               ka, kb;
  logic [NRD*RAW-1:0]  rd_addr;
  logic [NRD*WORD_W-1:0] rd_data;
  logic [WORD_W-1:0]   rf_a, rf_b, rf_t;
  logic                legal, use_ind, ind_slot, ind_local, accept, go_ind, hold_v;
  logic [MAW-1:0]      ind_addr;
  logic [WORD_W-1:0]   val_a, val_b, hold_a, hold_b;

  assign ka = kind_e'(a_kind);
  assign kb = kind_e'(b_kind);

  assign rd_addr = {ind_addr[RAW-1:0], b_reg, a_reg};
  assign rf_a    = rd_data[0*WORD_W +: WORD_W];
  assign rf_b    = rd_data[1*WORD_W +: WORD_W];
  assign rf_t    = rd_data[2*WORD_W +: WORD_W];

  opnd_regfile #(.RAW(RAW), .NRD(NRD)) u_rf (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_word (wr_word),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  opnd_check #(.RAW(RAW), .MAW(MAW)) u_chk (
    .size_word (size_word),
    .a_kind    (ka),
    .b_kind    (kb),
    .a_reg     (a_reg),
    .b_reg     (b_reg),
    .dst_reg   (dst_reg),
    .ptr_a     (rf_a),
    .ptr_b     (rf_b),
    .legal     (legal),
    .use_ind   (use_ind),
    .ind_slot  (ind_slot),
    .ind_local (ind_local),
    .ind_addr  (ind_addr)
  );

  always_comb begin
    val_a  = fit(size_word, (ka == K_IMM) ? imm : rf_a);
    val_b  = fit(size_word, (kb == K_IMM) ? imm : rf_b);
    accept = issue & ready;
    go_ind = accept & legal & use_ind;
  end

  opnd_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_ind     (go_ind),
    .ind_local  (ind_local),
    .ind_slot   (ind_slot),
    .size_word  (size_word),
    .val_a      (val_a),
    .val_b      (val_b),
    .local_data (rf_t),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .ready      (ready),
    .hold_v     (hold_v),
    .hold_a     (hold_a),
    .hold_b     (hold_b)
  );

  assign done     = hold_v | (accept & legal & ~use_ind);
  assign illegal  = accept & ~legal;
  assign mem_req  = go_ind & ~ind_local;
  assign mem_addr = ind_addr;
  assign mem_word = size_word;
  assign opnd_a   = hold_v ? hold_a : val_a;
  assign opnd_b   = hold_v ? hold_b : val_b;

  AST_REQ_NOT_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !illegal); // R6
  AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!done && !mem_req)); // R3
  AST_REQ_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_word) |-> !mem_addr[0]); // R6
  AST_REQ_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !ready); // R9
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (!illegal && !mem_req)); // R9
endmodule

// File: tb/opnd_resolver_test.sv
`timescale 1ns/1ps
module opnd_resolver_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_word, issue, size_word, mem_ack;
  logic [7:0]  wr_addr, a_reg, b_reg, dst_reg;
  logic [15:0] wr_data, imm, mem_rdata;
  logic [1:0]  a_kind, b_kind;
  logic        ready, done, illegal, mem_req, mem_word;
  logic [15:0] opnd_a, opnd_b, mem_addr;

  int nchk = 0;
  int nerr = 0;
  logic [7:0] mdl [256];

  always #2.5 clk = ~clk;

  opnd_resolver uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .wr_addr(wr_addr),
    .wr_data(wr_data), .issue(issue), .size_word(size_word), .a_kind(a_kind),
    .a_reg(a_reg), .b_kind(b_kind), .b_reg(b_reg), .dst_reg(dst_reg), .imm(imm),
    .ready(ready), .done(done), .illegal(illegal), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_word(mem_word),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic        sw;
    logic [1:0]  ak;
    logic [7:0]  ar;
    logic [1:0]  bk;
    logic [7:0]  br;
    logic [7:0]  dr;
    logic [15:0] im;
    logic        ed;
    logic        ei;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{4'd1, 1'b0, 2'd0, 8'h11, 2'd0, 8'h23, 8'h05, 16'h0000, 1'b1, 1'b0}, // R1 byte regs
    '{4'd1, 1'b1, 2'd0, 8'h10, 2'd0, 8'h2E, 8'h06, 16'h0000, 1'b1, 1'b0}, // R1 word regs
    '{4'd2, 1'b1, 2'd0, 8'h20, 2'd1, 8'h00, 8'h20, 16'hBEEF, 1'b1, 1'b0}, // R2 word imm
    '{4'd2, 1'b0, 2'd1, 8'h00, 2'd0, 8'h33, 8'h07, 16'h12AB, 1'b1, 1'b0}, // R2 byte imm
    '{4'd3, 1'b1, 2'd0, 8'h13, 2'd0, 8'h10, 8'h10, 16'h0000, 1'b0, 1'b1}, // R3 odd src
    '{4'd3, 1'b1, 2'd0, 8'h10, 2'd0, 8'h12, 8'h09, 16'h0000, 1'b0, 1'b1}, // R3 odd dst
    '{4'd4, 1'b0, 2'd1, 8'h00, 2'd1, 8'h00, 8'h00, 16'h0001, 1'b0, 1'b1}, // R4 two imm
    '{4'd4, 1'b0, 2'd1, 8'h00, 2'd2, 8'h40, 8'h00, 16'h0001, 1'b0, 1'b1}, // R4 imm+ind
    '{4'd4, 1'b0, 2'd3, 8'h10, 2'd0, 8'h10, 8'h00, 16'h0000, 1'b0, 1'b1}, // R4 kind 3
    '{4'd5, 1'b0, 2'd2, 8'h41, 2'd0, 8'h10, 8'h00, 16'h0000, 1'b0, 1'b1}, // R5 odd ptr
    '{4'd6, 1'b1, 2'd2, 8'h42, 2'd0, 8'h10, 8'h10, 16'h0000, 1'b0, 1'b1}  // R6 odd target
  };

  task automatic chk(input string rq, input string what, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mval(input logic [1:0] k, input logic [7:0] r, input logic sw,
                                       input logic [15:0] im);
    logic [15:0] w;
    w = (k == 2'd1) ? im : {mdl[{r[7:1], 1'b1}], mdl[r]};
    if (k == 2'd0 && sw) w = {mdl[{r[7:1], 1'b1}], mdl[{r[7:1], 1'b0}]};
    return sw ? w : {8'h00, w[7:0]};
  endfunction

  task automatic wr(input logic w, input logic [7:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_word = w; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (w) begin
      mdl[{a[7:1], 1'b0}] = d[7:0];
      mdl[{a[7:1], 1'b1}] = d[15:8];
    end else mdl[a] = d[7:0];
  endtask

  task automatic put(input logic sw, input logic [1:0] ak, input logic [7:0] ar,
                     input logic [1:0] bk, input logic [7:0] br, input logic [7:0] dr,
                     input logic [15:0] im);
    issue = 1'b1; size_word = sw; a_kind = ak; a_reg = ar; b_kind = bk; b_reg = br;
    dst_reg = dr; imm = im;
  endtask

  initial begin
    #(200000 * 5);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [15:0] keep_b;
    rst_n = 1'b0; wr_en = 1'b0; wr_word = 1'b0; wr_addr = '0; wr_data = '0;
    issue = 1'b0; size_word = 1'b0; a_kind = '0; a_reg = '0; b_kind = '0; b_reg = '0;
    dst_reg = '0; imm = '0; mem_ack = 1'b0; mem_rdata = '0;
    #1;
    chk("R10", "ready", {15'd0, ready}, 16'd1);
    chk("R10", "done", {15'd0, done}, 16'd0);
    chk("R10", "illegal", {15'd0, illegal}, 16'd0);
    chk("R10", "mem_req", {15'd0, mem_req}, 16'd0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 128; i++) wr(1'b1, 8'(2 * i), {8'(i * 29 + 7), 8'(i * 13 + 90)});
    wr(1'b1, 8'h40, 16'h1234);
    wr(1'b1, 8'h42, 16'h1235);
    wr(1'b1, 8'h44, 16'h0031);
    wr(1'b1, 8'h46, 16'h0030);

    // R11: byte write touches only the odd byte, read back as a word
    wr(1'b0, 8'h21, 16'hFF77);
    put(1'b1, 2'd0, 8'h20, 2'd0, 8'h22, 8'h00, 16'h0);
    #1;
    chk("R11", "word readback", opnd_a, {8'h77, mdl[8'h20]});
    @(negedge clk); issue = 1'b0;

    for (int v = 0; v < NV; v++) begin
      put(TBL[v].sw, TBL[v].ak, TBL[v].ar, TBL[v].bk, TBL[v].br, TBL[v].dr, TBL[v].im);
      #1;
      chk($sformatf("R%0d row%0d", TBL[v].rq, v), "done", {15'd0, done}, {15'd0, TBL[v].ed});
      chk($sformatf("R%0d row%0d", TBL[v].rq, v), "illegal", {15'd0, illegal}, {15'd0, TBL[v].ei});
      chk($sformatf("R%0d row%0d", TBL[v].rq, v), "mem_req", {15'd0, mem_req}, 16'd0);
      if (TBL[v].ed) begin
        chk($sformatf("R%0d row%0d", TBL[v].rq, v), "opnd_a", opnd_a,
            mval(TBL[v].ak, TBL[v].ar, TBL[v].sw, TBL[v].im));
        chk($sformatf("R%0d row%0d", TBL[v].rq, v), "opnd_b", opnd_b,
            mval(TBL[v].bk, TBL[v].br, TBL[v].sw, TBL[v].im));
      end
      @(negedge clk);
    end
    issue = 1'b0;

    // R6/R7: word indirect through 0x40, register file changes while waiting
    keep_b = mval(2'd0, 8'h10, 1'b1, 16'h0);
    put(1'b1, 2'd2, 8'h40, 2'd0, 8'h10, 8'h10, 16'h0);
    #1;
    chk("R6", "mem_req", {15'd0, mem_req}, 16'd1);
    chk("R6", "mem_addr", mem_addr, 16'h1234);
    chk("R6", "mem_word", {15'd0, mem_word}, 16'd1);
    chk("R6", "done early", {15'd0, done}, 16'd0);
    @(negedge clk);
    // R9: busy, a new issue is ignored
    put(1'b1, 2'd0, 8'h13, 2'd0, 8'h10, 8'h10, 16'h0);
    #1;
    chk("R9", "ready", {15'd0, ready}, 16'd0);
    chk("R9", "illegal while busy", {15'd0, illegal}, 16'd0);
    chk("R9", "done while busy", {15'd0, done}, 16'd0);
    @(negedge clk);
    issue = 1'b0;
    chk("R9", "still waiting", {15'd0, done}, 16'd0);
    mem_ack = 1'b1; mem_rdata = 16'hCAFE;
    wr(1'b1, 8'h10, 16'h5555);
    mem_ack = 1'b0;
    #1;
    chk("R7", "done after ack", {15'd0, done}, 16'd1);
    chk("R7", "indirect slot", opnd_a, 16'hCAFE);
    chk("R7", "held slot", opnd_b, keep_b);
    @(negedge clk);
    chk("R9", "ready after done", {15'd0, ready}, 16'd1);
    chk("R7", "done single", {15'd0, done}, 16'd0);

    // R7: byte indirect in slot B to odd external address
    put(1'b0, 2'd0, 8'h11, 2'd2, 8'h42, 8'h00, 16'h0);
    #1;
    chk("R6", "byte mem_addr", mem_addr, 16'h1235);
    chk("R6", "byte mem_word", {15'd0, mem_word}, 16'd0);
    @(negedge clk);
    issue = 1'b0; mem_ack = 1'b1; mem_rdata = 16'h9988;
    @(negedge clk);
    mem_ack = 1'b0;
    #1;
    chk("R7", "byte indirect B", opnd_b, 16'h0088);
    chk("R7", "byte held A", opnd_a, mval(2'd0, 8'h11, 1'b0, 16'h0));
    @(negedge clk);

    // R8: indirect inside the register file
    put(1'b1, 2'd2, 8'h46, 2'd0, 8'h20, 8'h00, 16'h0);
    #1;
    chk("R8", "no mem_req", {15'd0, mem_req}, 16'd0);
    chk("R8", "not done at issue", {15'd0, done}, 16'd0);
    @(negedge clk);
    issue = 1'b0;
    #1;
    chk("R8", "done", {15'd0, done}, 16'd1);
    chk("R8", "local word", opnd_a, {mdl[8'h31], mdl[8'h30]});
    @(negedge clk);
    put(1'b0, 2'd0, 8'h20, 2'd2, 8'h44, 8'h00, 16'h0);
    #1;
    chk("R8", "byte no mem_req", {15'd0, mem_req}, 16'd0);
    @(negedge clk);
    issue = 1'b0;
    #1;
    chk("R8", "local byte odd", opnd_b, {8'h00, mdl[8'h31]});
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule